// File: doc/BRIEF.md
# Half-Bridge Switch Sequencer

This block turns a handful of asynchronous logic inputs into two on/off commands, one for the high-side switch and one for the low-side switch of a push-pull output stage. A mode input selects between two ways of driving it. With mode high, each command input owns one switch: `pin` requests the high side and `nin` requests the low side. When both are requested at once, both switches are held off. With mode low, only `nin` is used. It drives the two switches in a complementary way, and a dead interval set by `dead_cnt` always separates the turn-off of one switch from the turn-on of the other.

Every on period lasts at least `MIN_PW` clock cycles, however short the request is. An enable and a reset-good input gate the whole block. Either one going low switches both sides off at once, even in the middle of a minimum pulse. After both are high again, switching resumes only once `EN_DLY` cycles have passed. All five control inputs pass through a two-flop synchronizer before use. Their reset values are: mode high, all other inputs low.

A four-state machine holds the output state:
- `ST_IDLE`: both switches off.
- `ST_HIGH`: high side on.
- `ST_LOW`: low side on.
- `ST_GAP`: both switches off while the dead interval runs.

Its transitions are:
- Gating off (enable or reset-good low, or the enable delay still running) sends any state to `ST_IDLE`.
- A request moves `ST_IDLE` to `ST_HIGH` or to `ST_LOW`.
- Once the minimum width has been served and its request is gone, an on state moves as follows. In single-control mode it goes to `ST_GAP`. In dual-control mode it goes straight to the other on state if that side is requested, and to `ST_IDLE` otherwise.
- When the dead interval ends, `ST_GAP` moves to whichever side is then requested, or to `ST_IDLE`.

Top module: `hb_gate_ctrl`

## Requirements
- R1: In dual-control mode (`mode`=1), `pin`=1 with `nin`=0 turns `p_on` on and `n_on` off, `nin`=1 with `pin`=0 turns `n_on` on and `p_on` off, and both low gives both off.
- R2: `p_on` and `n_on` are never 1 in the same cycle; in dual-control mode `pin`=`nin`=1 drives both off.
- R3: In single-control mode (`mode`=0), `nin`=1 gives `p_on`=1, `n_on`=0 and `nin`=0 gives `p_on`=0, `n_on`=1; `pin` has no effect on either output.
- R4: In single-control mode every handover between the two sides leaves both off for exactly `dead_cnt` cycles, with a value of 0 treated as 1.
- R5: In dual-control mode no dead interval is added: when the inputs swap sides on the same clock, one output falls on the same edge as the other rises.
- R6: Each on period lasts at least `MIN_PW` cycles; a request held for `MIN_PW` cycles or longer gives an on period of the same length.
- R7: `enable`=0 or `reset_ok`=0 forces both outputs off on the third rising edge after the change, even during a minimum-width hold.
- R8: After `enable` and `reset_ok` are both 1 (or after `rst_n` is released with them high), both outputs stay off for `EN_DLY`+2 edges, and the first output can switch on at edge `EN_DLY`+3.
- R9: A change on a control input reaches the outputs on the third rising edge: after two edges the outputs still show the old state.
- R10: While `rst_n` is low, both outputs are off at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin | input | 1 | High-side request (used in dual-control mode only) |
| nin | input | 1 | Low-side request in dual-control mode; PWM input in single-control mode |
| mode | input | 1 | 1 = dual-control, 0 = single-control |
| enable | input | 1 | 1 allows switching |
| reset_ok | input | 1 | 1 when the supply reset is released |
| dead_cnt | input | DT_W | Dead interval in cycles for single-control mode (0 acts as 1) |
| p_on | output | 1 | High-side switch command |
| n_on | output | 1 | Low-side switch command |

## Verification
Dual-control mode is tried with each input alone, with both together, and with a same-clock swap of sides. Together these separate plain decoding, the lockout, and the absence of a dead interval, which the swap shows as a gap of zero cycles. Single-control mode is tried with `nin` toggling at dead counts of 0, 1, 5 and 15, and with `pin` toggled while `nin` is held. The gap lengths in both directions show that the count is honoured and that zero is clamped to one. One-cycle and ten-cycle requests separate the pulse stretch from plain following of the input. Dropping enable, dropping reset-good and asserting reset in the middle of a run show the forced-off path and the re-enable delay.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_GAP  = 2'd3
    } leg_state_e;

    typedef struct packed {
        logic pin;
        logic nin;
        logic mode;
        logic enable;
        logic rst_ok;
    } ctrl_in_t;

    localparam ctrl_in_t CTRL_RESET = '{pin: 1'b0, nin: 1'b0, mode: 1'b1,
                                        enable: 1'b0, rst_ok: 1'b0};

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stage;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage <= {2{RST_VAL[i]}};
            else        stage <= {stage[0], d[i]};
        end
        assign q[i] = stage[1];
    end
endmodule

// File: rtl/hbg_enable_gate.sv
module hbg_enable_gate #(
    parameter int EN_DLY = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic ok_s,
    output logic run
);
    localparam int          CW    = $clog2(EN_DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(EN_DLY);

    logic [CW-1:0] wait_cnt;
    logic          allowed;

    assign allowed = en_s && ok_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              wait_cnt <= '0;
        else if (!allowed)       wait_cnt <= '0;
        else if (wait_cnt != LIMIT) wait_cnt <= wait_cnt + CW'(1);
    end

    assign run = allowed && (wait_cnt == LIMIT);
endmodule

// File: rtl/hbg_demand.sv
module hbg_demand (
    input  logic mode_s,
    input  logic pin_s,
    input  logic nin_s,
    output logic want_p,
    output logic want_n
);
    always_comb begin
        if (mode_s) begin
            want_p = pin_s && !nin_s;
            want_n = nin_s && !pin_s;
        end else begin
            want_p = nin_s;
            want_n = !nin_s;
        end
    end
endmodule

// File: rtl/hbg_leg_fsm.sv
module hbg_leg_fsm
    import hbg_pkg::*;
#(
    parameter int DT_W   = 6,
    parameter int MIN_PW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            mode_s,
    input  logic            want_p,
    input  logic            want_n,
    input  logic [DT_W-1:0] dead_cnt,
    output logic            p_on,
    output logic            n_on
);
    localparam int SPAN  = (MIN_PW > (1 << DT_W)) ? MIN_PW : (1 << DT_W);
    localparam int CNT_W = $clog2(SPAN + 1);

    leg_state_e       cur, nxt;
    logic [CNT_W-1:0] tick;
    logic [CNT_W-1:0] eff_dead;
    logic             min_done, gap_done;

    assign eff_dead = (dead_cnt == '0) ? CNT_W'(1) : CNT_W'(dead_cnt);
    assign min_done = tick >= CNT_W'(MIN_PW);
    assign gap_done = tick >= eff_dead;

    always_comb begin
        nxt = cur;
        if (!run) begin
            nxt = ST_IDLE;
        end else begin
            unique case (cur)
                ST_IDLE: begin
                    if (want_p)      nxt = ST_HIGH;
                    else if (want_n) nxt = ST_LOW;
                end
                ST_HIGH: begin
                    if (min_done && !want_p) begin
                        if (!mode_s)     nxt = ST_GAP;
                        else if (want_n) nxt = ST_LOW;
                        else             nxt = ST_IDLE;
                    end
                end
                ST_LOW: begin
                    if (min_done && !want_n) begin
                        if (!mode_s)     nxt = ST_GAP;
                        else if (want_p) nxt = ST_HIGH;
                        else             nxt = ST_IDLE;
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        if (want_p)      nxt = ST_HIGH;
                        else if (want_n) nxt = ST_LOW;
                        else             nxt = ST_IDLE;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= ST_IDLE;
        else        cur <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       tick <= '0;
        else if (nxt != cur)              tick <= CNT_W'(1);
        else if (tick != {CNT_W{1'b1}})   tick <= tick + CNT_W'(1);
    end

    always_comb begin
        p_on = (cur == ST_HIGH);
        n_on = (cur == ST_LOW);
    end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int DT_W   = 6,
    parameter int MIN_PW = 10,
    parameter int EN_DLY = 7500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin,
    input  logic            nin,
    input  logic            mode,
    input  logic            enable,
    input  logic            reset_ok,
    input  logic [DT_W-1:0] dead_cnt,
    output logic            p_on,
    output logic            n_on
);
    localparam int SW = $bits(ctrl_in_t);

    ctrl_in_t raw, syn;
    logic     en_s, ok_s, mode_s;
    logic     want_p, want_n, run;

    assign raw = '{pin: pin, nin: nin, mode: mode, enable: enable, rst_ok: reset_ok};

    hbg_sync #(.W(SW), .RST_VAL(CTRL_RESET)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign en_s   = syn.enable;
    assign ok_s   = syn.rst_ok;
    assign mode_s = syn.mode;

    hbg_enable_gate #(.EN_DLY(EN_DLY)) u_gate (
        .clk(clk), .rst_n(rst_n), .en_s(en_s), .ok_s(ok_s), .run(run)
    );

    hbg_demand u_demand (
        .mode_s(mode_s), .pin_s(syn.pin), .nin_s(syn.nin),
        .want_p(want_p), .want_n(want_n)
    );

    hbg_leg_fsm #(.DT_W(DT_W), .MIN_PW(MIN_PW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .mode_s(mode_s),
        .want_p(want_p), .want_n(want_n), .dead_cnt(dead_cnt),
        .p_on(p_on), .n_on(n_on)
    );
endmodule

// File: rtl/hbg_check.sv
module hbg_check #(
    parameter int MIN_PW = 10
) (
    input logic clk,
    input logic rst_n,
    input logic en_s,
    input logic ok_s,
    input logic mode_s,
    input logic run,
    input logic p_on,
    input logic n_on
);
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_on && n_on)); // R2

    AST_GATE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s || !ok_s) |=> (!p_on && !n_on)); // R7

    AST_ON_ONLY_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (p_on || n_on) |-> $past(run)); // R8

    AST_SINGLE_GAP_AFTER_P: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mode_s) && $fell(p_on)) |-> !n_on); // R4

    AST_SINGLE_GAP_AFTER_N: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mode_s) && $fell(n_on)) |-> !p_on); // R4

    if (MIN_PW >= 2) begin : g_hold
        AST_HOLD_P: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(p_on) && run) |=> p_on); // R6
        AST_HOLD_N: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(n_on) && run) |=> n_on); // R6
    end
endmodule

bind hb_gate_ctrl hbg_check #(.MIN_PW(MIN_PW)) u_check (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .ok_s(ok_s), .mode_s(mode_s),
    .run(run), .p_on(p_on), .n_on(n_on)
);

// File: tb/sim_hb_gate_ctrl.sv
`timescale 1ns/1ps
module sim_hb_gate_ctrl;
    localparam int DT_W   = 4;
    localparam int MIN_PW = 4;
    localparam int EN_DLY = 16;

    logic clk = 1'b0;
    logic rst_n, pin, nin, mode, enable, reset_ok;
    logic [DT_W-1:0] dead_cnt;
    logic p_on, n_on;

    int total = 0;
    int bad   = 0;
    int overlap = 0;

    typedef struct { bit p; bit n; string req; } lvl_t;
    lvl_t lvl_q[$];
    int   gap_q[$];
    int   pw_q[$];

    always #10 clk = ~clk;

    hb_gate_ctrl #(.DT_W(DT_W), .MIN_PW(MIN_PW), .EN_DLY(EN_DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .pin(pin), .nin(nin), .mode(mode),
        .enable(enable), .reset_ok(reset_ok), .dead_cnt(dead_cnt),
        .p_on(p_on), .n_on(n_on)
    );

    function automatic void note(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    // level scoreboard: compared 1 ns after each falling edge
    always @(negedge clk) begin
        #1;
        while (lvl_q.size() > 0) begin
            lvl_t it;
            it = lvl_q.pop_front();
            note((p_on == it.p) && (n_on == it.n), it.req,
                 {30'd0, p_on, n_on}, {30'd0, it.p, it.n});
        end
    end

    // R2: overlap watch every cycle
    always @(negedge clk) if (p_on && n_on) overlap++;

    // handover gap monitor (R4, R5)
    logic pp = 1'b0, pn = 1'b0;
    bit   armed = 0;
    bit   side_p = 0;
    int   zcnt = 0;
    int   hw = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            armed = 0;
            hw = 0;
        end else begin
            if (pp && !p_on) begin armed = 1; side_p = 1; zcnt = 0; end
            if (pn && !n_on) begin armed = 1; side_p = 0; zcnt = 0; end
            if (armed && !p_on && !n_on) zcnt++;
            if (armed && ((side_p && n_on && !pn) || (!side_p && p_on && !pp))) begin
                armed = 0;
                if (gap_q.size() > 0) begin
                    int e;
                    e = gap_q.pop_front();
                    note(zcnt == e, "R4/R5 handover gap", zcnt, e);
                end
            end
            // R6 pulse width on p_on
            if (p_on) hw++;
            else if (pp) begin
                if (pw_q.size() > 0) begin
                    int w;
                    w = pw_q.pop_front();
                    note(hw == w, "R6 pulse width", hw, w);
                end
                hw = 0;
            end
        end
        pp = p_on;
        pn = n_on;
    end

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic drv(input bit ip, input bit in_, input bit im, input bit ie, input bit ir);
        pin = ip; nin = in_; mode = im; enable = ie; reset_ok = ir;
    endtask

    task automatic expect_lv(input bit p, input bit n, input string req);
        lvl_t it;
        it.p = p; it.n = n; it.req = req;
        lvl_q.push_back(it);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        dead_cnt = 4'd1;
        drv(0, 0, 1, 0, 0);
        cyc(3);
        expect_lv(0, 0, "R10 reset state");
        cyc(1);
        rst_n = 1'b1;

        // R8: enable delay, dual mode with pin requested
        drv(1, 0, 1, 1, 1);
        cyc(EN_DLY + 2);
        expect_lv(0, 0, "R8 still waiting");
        cyc(1);
        expect_lv(1, 0, "R8 first switch-on / R1 pin");
        cyc(6);

        // R5: same-clock swap, no dead interval
        gap_q.push_back(0);
        drv(0, 1, 1, 1, 1);
        cyc(3);
        expect_lv(0, 1, "R1 nin alone");
        cyc(5);
        note(gap_q.size() == 0, "R5 swap observed", gap_q.size(), 0);
        drv(1, 0, 1, 1, 1);
        cyc(8);
        expect_lv(1, 0, "R1 pin alone");
        drv(0, 0, 1, 1, 1);
        cyc(8);
        expect_lv(0, 0, "R1 none requested");

        // R2: both requested
        drv(1, 0, 1, 1, 1);
        cyc(8);
        drv(1, 1, 1, 1, 1);
        cyc(8);
        expect_lv(0, 0, "R2 lockout");
        drv(0, 0, 1, 1, 1);
        cyc(6);

        // R6: short request stretched, long request followed
        pw_q.push_back(MIN_PW);
        pin = 1'b1;
        cyc(1);
        pin = 1'b0;
        cyc(12);
        note(pw_q.size() == 0, "R6 short pulse seen", pw_q.size(), 0);
        pw_q.push_back(10);
        pin = 1'b1;
        cyc(10);
        pin = 1'b0;
        cyc(15);
        note(pw_q.size() == 0, "R6 long pulse seen", pw_q.size(), 0);

        // R3: single-control mode
        drv(0, 1, 0, 1, 1);
        cyc(6);
        expect_lv(1, 0, "R3 nin high");
        pin = 1'b1;
        cyc(2);
        expect_lv(1, 0, "R3 pin ignored");
        cyc(4);
        expect_lv(1, 0, "R3 pin ignored");
        pin = 1'b0;
        cyc(4);

        // R4: dead interval at several counts, both directions
        foreach (gap_q[i]) ;
        for (int k = 0; k < 4; k++) begin
            int d, eff;
            d = (k == 0) ? 5 : (k == 1) ? 0 : (k == 2) ? 1 : 15;
            eff = (d == 0) ? 1 : d;
            dead_cnt = DT_W'(d);
            cyc(2);
            gap_q.push_back(eff);
            nin = 1'b0;
            cyc(3);
            expect_lv(0, 0, "R4 both off after P falls");
            cyc(eff + 4);
            note(gap_q.size() == 0, "R4 gap P to N seen", gap_q.size(), 0);
            expect_lv(0, 1, "R3 nin low");
            gap_q.push_back(eff);
            nin = 1'b1;
            cyc(eff + 8);
            note(gap_q.size() == 0, "R4 gap N to P seen", gap_q.size(), 0);
            expect_lv(1, 0, "R3 nin high again");
        end

        // R9 / R7: enable low
        dead_cnt = 4'd1;
        enable = 1'b0;
        cyc(2);
        expect_lv(1, 0, "R9 two edges no change");
        cyc(1);
        expect_lv(0, 0, "R7 enable low");
        enable = 1'b1;
        cyc(EN_DLY + 2);
        expect_lv(0, 0, "R8 re-enable wait");
        cyc(1);
        expect_lv(1, 0, "R8 re-enable on");
        cyc(4);

        // R7: reset_ok low
        reset_ok = 1'b0;
        cyc(3);
        expect_lv(0, 0, "R7 reset_ok low");
        reset_ok = 1'b1;
        cyc(EN_DLY + 3);
        expect_lv(1, 0, "R8 after reset_ok");
        cyc(4);

        // R10: reset in the middle of a run
        rst_n = 1'b0;
        #1;
        note(!p_on && !n_on, "R10 async off", {31'd0, p_on | n_on}, 0);
        cyc(2);
        rst_n = 1'b1;
        cyc(EN_DLY + 2);
        expect_lv(0, 0, "R10 wait after reset");
        cyc(1);
        expect_lv(1, 0, "R10 resume after reset");
        cyc(3);

        note(overlap == 0, "R2 never both on", overlap, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule